// File: doc/BRIEF.md
# Key-Guarded DRAM Controller Configuration Registers

This block is the software-visible register front end of a DRAM controller. It sits on a simple 32-bit word bus with a byte address, write data, write and read strobes, and registered read data. It holds the settings that the rest of the controller consumes. Every register except the guard word ignores writes until software has stored a fixed 32-bit key into the guard word. Storing any other value there locks the block again.

The configuration word carries a memory-size code, a display-aperture code, a display-compatibility flag and a number of option bits that are only stored here. Two silicon variants are supported through a parameter. They differ in which configuration bits are read-only, in the reset value of the configuration word, and in how the installed memory size, also a parameter, maps to the 2-bit size code. Any rejected access raises a one-cycle error pulse. A rejected access is a write while locked, or any access past the implemented words. The current lock state is driven on a status output.

Top module: `memcfg_regs`

## Requirements
- R1: After reset `unlocked` is 0, `err` is 0, the guard word (byte 0x000) reads 0, and every general word (byte 0x008 upward) reads 0. The configuration word (byte 0x004) reads `0x40 | size` for variant A (VARIANT=0). It reads `0x1000000C | size` for variant B (VARIANT=1).
- R2: The size code sits in configuration bits 1:0. Variant A maps 64/128/256/512 MB to 0/1/2/3, and any other MEM_MB to 2. Variant B maps 128/256/512/1024 MB to 0/1/2/3, and any other MEM_MB to 2.
- R3: A write to word 0 is always accepted. Data 0xFC600309 sets the lock state to 1, which means unlocked. Any other data sets it to 0. The state shows on `unlocked` from the next cycle, and a read of word 0 returns it in bit 0 with all other bits zero.
- R4: While the lock state is 0, a write to any other in-range word leaves that word unchanged and raises `err`.
- R5: An accepted write to the configuration word keeps the read-only bits and loads every other bit from `wdata`. For variant A the read-only mask is 0xFFFFF84C. For variant B it is 0xF00FC04C.
- R6: While unlocked, general words 2 to NUM_WORDS-1 store the full 32-bit write data and read it back unchanged.
- R7: An access whose word index is at least NUM_WORDS reads 0, changes no register (the lock state included) and raises `err`.
- R8: `err` is high for exactly the cycle after a rejected access, and is low after an accepted one. `rdata` is updated in the cycle after `rd_en`.
- R9: The word index is `addr >> 2`, and address bits 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address within the 4 KiB window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| unlocked | output | 1 | Current lock state (1 = writes permitted) |
| err | output | 1 | One-cycle pulse after a rejected access |

## Verification
On every cycle the assertions check four things. The read-only configuration bits never move. A locked write to the configuration word leaves it stable. The lock state changes only after a write to word 0, and a key write always unlocks. An error pulse always follows a bus request, and an out-of-range read always returns zero. Only the bench scenarios can show the concrete values. These are the reset words for each variant, the size-code fallback for an unsupported size, the exact merge of writable and read-only bits, and that an out-of-range write does not alias onto the guard word. They also cover the ignored low address bits and the error pulse clearing one cycle later.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

   localparam logic [31:0] GUARD_KEY = 32'hFC60_0309;

   // read-only bit masks of the configuration word, per variant
   localparam logic [31:0] RO_MASK_A = 32'hFFFF_F84C;
   localparam logic [31:0] RO_MASK_B = 32'hF00F_C04C;

   typedef struct packed {
      logic        in_range;
      logic        hit_guard;
      logic        hit_conf;
   } decode_t;

   function automatic logic [1:0] size_code(input int variant, input int mb);
      logic [1:0] c;
      c = 2'd2;
      if (variant == 0) begin
         case (mb)
            64:      c = 2'd0;
            128:     c = 2'd1;
            256:     c = 2'd2;
            512:     c = 2'd3;
            default: c = 2'd2;
         endcase
      end else begin
         case (mb)
            128:     c = 2'd0;
            256:     c = 2'd1;
            512:     c = 2'd2;
            1024:    c = 2'd3;
            default: c = 2'd2;
         endcase
      end
      return c;
   endfunction

   function automatic logic [31:0] conf_reset(input int variant, input int mb);
      logic [31:0] v;
      if (variant == 0) v = 32'h0000_0040;
      else              v = 32'h1000_000C;
      v[1:0] = size_code(variant, mb);
      return v;
   endfunction

endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode
   import memcfg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_WORDS = 8,
   localparam int IDX_W    = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output decode_t           dec
);

   logic unused_low_bits;
   assign unused_low_bits = ^addr[1:0];   // R9: byte lanes within a word ignored

   assign idx = addr[ADDR_W-1:2];

   always_comb begin
      dec.in_range  = (32'(idx) < 32'(NUM_WORDS));
      dec.hit_guard = (idx == '0);
      dec.hit_conf  = (idx == IDX_W'(1));
   end

endmodule

// File: rtl/memcfg_guard.sv
module memcfg_guard
   import memcfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  decode_t     dec,
   input  logic [31:0] wdata,
   output logic        unlocked,
   output logic        wr_ok,
   output logic        err
);

   logic lock_q;
   logic err_q;
   logic reject;

   assign wr_ok  = wr_en && dec.in_range && !dec.hit_guard && lock_q;
   assign reject = (wr_en && (!dec.in_range || (!dec.hit_guard && !lock_q)))
                || (rd_en && !dec.in_range);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (wr_en && dec.in_range && dec.hit_guard)
            lock_q <= (wdata == GUARD_KEY);
         err_q <= reject;
      end
   end

   assign unlocked = lock_q;
   assign err      = err_q;

   p_key_unlocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec.in_range && dec.hit_guard && wdata == GUARD_KEY) |=> unlocked);

   p_lock_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(unlocked) |-> $past(wr_en && dec.in_range && dec.hit_guard));

   p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(wr_en || rd_en));

endmodule

// File: rtl/memcfg_store.sv
module memcfg_store
   import memcfg_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int VARIANT   = 0,
   parameter int MEM_MB    = 256,
   localparam int IDX_W    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_val,
   output logic [31:0]      conf
);

   localparam logic [31:0] CONF_RST = conf_reset(VARIANT, MEM_MB);

   logic [31:0] ro_mask;
   logic [31:0] words [NUM_WORDS];
   logic [31:0] conf_q;

   generate
      if (VARIANT == 0) begin : g_var_a
         assign ro_mask = RO_MASK_A;
      end else begin : g_var_b
         assign ro_mask = RO_MASK_B;
      end
   endgenerate

   // configuration word: read-only bits survive every write
   always_ff @(posedge clk) begin
      if (!rst_n)
         conf_q <= CONF_RST;
      else if (wr_ok && idx == IDX_W'(1))
         conf_q <= (conf_q & ro_mask) | (wdata & ~ro_mask);
   end

   generate
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
         if (k == 0) begin : g_guard_slot
            assign words[k] = '0;
         end else if (k == 1) begin : g_conf_slot
            assign words[k] = conf_q;
         end else begin : g_plain
            logic [31:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= '0;
               else if (wr_ok && idx == IDX_W'(k))
                  q <= wdata;
            end
            assign words[k] = q;
         end
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      for (int j = 0; j < NUM_WORDS; j++)
         if (idx == IDX_W'(j)) rd_val = words[j];
   end

   assign conf = conf_q;

   p_ro_bits_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(conf & ro_mask));

endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
   import memcfg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_WORDS = 8,
   parameter int VARIANT   = 0,
   parameter int MEM_MB    = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [31:0]       rdata,
   output logic              unlocked,
   output logic              err
);

   localparam int IDX_W = ADDR_W - 2;

   generate
      if (ADDR_W != 12) begin : g_bad_addr
         $error("memcfg_regs: ADDR_W must be 12 for a 4 KiB window");
      end
      if (NUM_WORDS < 2 || NUM_WORDS > (1 << IDX_W)) begin : g_bad_words
         $error("memcfg_regs: NUM_WORDS out of range");
      end
      if (VARIANT != 0 && VARIANT != 1) begin : g_bad_variant
         $error("memcfg_regs: VARIANT must be 0 or 1");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   decode_t          dec;
   logic             wr_ok;
   logic [31:0]      store_val;
   logic [31:0]      conf;
   logic [31:0]      rdata_q;

   memcfg_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
      .addr (addr),
      .idx  (idx),
      .dec  (dec)
   );

   memcfg_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .dec      (dec),
      .wdata    (wdata),
      .unlocked (unlocked),
      .wr_ok    (wr_ok),
      .err      (err)
   );

   memcfg_store #(.NUM_WORDS(NUM_WORDS), .VARIANT(VARIANT), .MEM_MB(MEM_MB)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .idx    (idx),
      .wdata  (wdata),
      .rd_val (store_val),
      .conf   (conf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en) begin
         if (!dec.in_range)      rdata_q <= '0;
         else if (dec.hit_guard) rdata_q <= {31'b0, unlocked};
         else                    rdata_q <= store_val;
      end
   end

   assign rdata = rdata_q;

   p_locked_conf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec.hit_conf && !unlocked) |=> $stable(conf));

   p_oor_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !dec.in_range) |=> (rdata == '0));

endmodule

// File: tb/tb_memcfg_regs.sv
`timescale 1ns/1ps
module tb_memcfg_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_a, rd_b, rd_c;
   logic        unl_a, unl_b, unl_c;
   logic        err_a, err_b, err_c;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   // variant A, 256 MB (code 2)
   memcfg_regs #(.VARIANT(0), .MEM_MB(256)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rd_a), .unlocked(unl_a), .err(err_a));

   // variant B, unsupported 1000 MB -> fallback code 2
   memcfg_regs #(.VARIANT(1), .MEM_MB(1000)) dut_b (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rd_b), .unlocked(unl_b), .err(err_b));

   // variant A, 64 MB (code 0)
   memcfg_regs #(.VARIANT(0), .MEM_MB(64)) dut_c (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rd_c), .unlocked(unl_c), .err(err_c));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "unlocked after reset", {31'b0, unl_a}, 32'd0);
      chk("R1", "err after reset", {31'b0, err_a}, 32'd0);
      bus_rd(12'h004);
      chk("R1", "conf A reset", rd_a, 32'h0000_0042);
      chk("R2", "conf B fallback size", rd_b, 32'h1000_000E);
      chk("R2", "conf A 64MB code", rd_c, 32'h0000_0040);
      bus_rd(12'h000);
      chk("R1", "guard word reset", rd_a, 32'd0);
      bus_rd(12'h01C);
      chk("R1", "general word reset", rd_a, 32'd0);
   endtask

   task automatic t_locked;
      bus_wr(12'h004, 32'hFFFF_FFFF);
      chk("R4", "err on locked conf write", {31'b0, err_a}, 32'd1);
      bus_rd(12'h004);
      chk("R4", "conf A unchanged while locked", rd_a, 32'h0000_0042);
      chk("R4", "conf B unchanged while locked", rd_b, 32'h1000_000E);
      bus_wr(12'h008, 32'h0000_A5A5);
      chk("R4", "err on locked word write", {31'b0, err_a}, 32'd1);
      bus_rd(12'h008);
      chk("R4", "word 2 unchanged while locked", rd_a, 32'd0);
   endtask

   task automatic t_key;
      bus_wr(12'h000, 32'h1234_5678);
      chk("R3", "no err on guard write", {31'b0, err_a}, 32'd0);
      chk("R3", "wrong key stays locked", {31'b0, unl_a}, 32'd0);
      bus_wr(12'h000, 32'hFC60_0308);
      chk("R3", "near key stays locked", {31'b0, unl_a}, 32'd0);
      bus_wr(12'h000, 32'hFC60_0309);
      chk("R3", "key unlocks", {31'b0, unl_a}, 32'd1);
      chk("R3", "key unlocks B", {31'b0, unl_b}, 32'd1);
      bus_rd(12'h000);
      chk("R3", "guard word reads 1", rd_a, 32'd1);
   endtask

   task automatic t_conf;
      bus_wr(12'h004, 32'hFFFF_FFFF);
      chk("R8", "no err on accepted write", {31'b0, err_a}, 32'd0);
      bus_rd(12'h004);
      chk("R5", "conf A all-ones merge", rd_a, 32'h0000_07F3);
      chk("R5", "conf B all-ones merge", rd_b, 32'h1FF0_3FBF);
      bus_wr(12'h004, 32'h0000_0000);
      bus_rd(12'h004);
      chk("R5", "conf A zero merge", rd_a, 32'h0000_0040);
      chk("R5", "conf B zero merge", rd_b, 32'h1000_000C);
   endtask

   task automatic t_words;
      bus_wr(12'h008, 32'hDEAD_BEEF);
      bus_wr(12'h01C, 32'h1357_9BDF);
      bus_rd(12'h008);
      chk("R6", "word 2 readback", rd_a, 32'hDEAD_BEEF);
      bus_rd(12'h01C);
      chk("R6", "word 7 readback", rd_a, 32'h1357_9BDF);
      bus_wr(12'h00B, 32'h0BAD_F00D);
      bus_rd(12'h009);
      chk("R9", "low address bits ignored", rd_a, 32'h0BAD_F00D);
   endtask

   task automatic t_out_of_range;
      bus_wr(12'h020, 32'h0000_0001);
      chk("R7", "err on out-of-range write", {31'b0, err_a}, 32'd1);
      @(negedge clk);
      chk("R8", "err drops after one cycle", {31'b0, err_a}, 32'd0);
      chk("R7", "oor write leaves lock state", {31'b0, unl_a}, 32'd1);
      bus_rd(12'h020);
      chk("R7", "oor read is zero", rd_a, 32'd0);
      chk("R7", "err on oor read", {31'b0, err_a}, 32'd1);
      bus_rd(12'hFFC);
      chk("R7", "top of window reads zero", rd_a, 32'd0);
      bus_rd(12'h01C);
      chk("R7", "word 7 untouched", rd_a, 32'h1357_9BDF);
      chk("R8", "no err on in-range read", {31'b0, err_a}, 32'd0);
   endtask

   task automatic t_relock;
      bus_wr(12'h000, 32'h0000_0000);
      chk("R3", "other value relocks", {31'b0, unl_a}, 32'd0);
      bus_rd(12'h000);
      chk("R3", "guard word reads 0", rd_a, 32'd0);
      bus_wr(12'h008, 32'h0000_0055);
      chk("R4", "err after relock", {31'b0, err_a}, 32'd1);
      bus_rd(12'h008);
      chk("R4", "word 2 kept after relock", rd_a, 32'h0BAD_F00D);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_key();
      t_conf();
      t_words();
      t_out_of_range();
      t_relock();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule